// File: doc/BRIEF.md
# Keyed Watchdog with Early Warning

This block is a watchdog timer. Software keeps it alive by writing one control word. The word holds a 7-bit key, an enable bit and a reload count. Once the watchdog runs, a write takes effect only if its key is the bitwise inverse of the key last accepted. A stray or runaway write with a stale key is therefore dropped.

The counter steps down once per pulse on a slow tick-enable input, nominally about 760 Hz, which comes from outside the block. The first time the count runs out, the block raises a non-maskable interrupt (NMI) and reloads a short grace count. Software can use that window to recover. If the grace count also runs out, the block emits a one-cycle system reset request. An accepted write clears the NMI and the stage flag. The current count and stage flag are always visible as status outputs.

Top module: `wdt_keyed`

## Requirements
- R1: After rst_ni is asserted low, nmi_o=0, rst_req_o=0, cnt_o=0 and stage_o=0, and the watchdog is disabled, so the next write is accepted whatever its key.
- R2: A control word wr_data_i is decoded as follows. Key is bits 15:9. Enable is bit 8. The reload count is bits 8:0, so the count shares bit 8 with enable.
- R3: While enabled, a write whose key is not the bitwise inverse of the stored key is discarded. Key, enable, count, nmi_o and stage_o stay as they were. While disabled, every write is accepted.
- R4: An accepted write clears nmi_o and stage_o in the cycle after the write.
- R5: An accepted write with enable set loads cnt_o from the count field and starts counting. An accepted write with enable clear stops the counter and leaves cnt_o unchanged.
- R6: While running, each cycle with tick_i high lowers cnt_o by one. Without tick_i, cnt_o holds. A write has priority over a tick in the same cycle.
- R7: In stage 0, a tick while cnt_o is 1 or 0 is the first expiry. It sets nmi_o=1 and stage_o=1, and loads cnt_o with GRACE (default 1).
- R8: In stage 1, a tick while cnt_o is 1 or 0 drives rst_req_o high for exactly one cycle. It also sets cnt_o to 0 and stops the counter, so later ticks have no effect.
- R9: cnt_o and stage_o report the live counter value and the stage flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow count-enable pulse |
| wr_i | input | 1 | Control write strobe |
| wr_data_i | input | 16 | Control word: key, enable, count |
| nmi_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | One-cycle system reset request |
| cnt_o | output | 9 | Current count (status) |
| stage_o | output | 1 | Set after the first expiry (status) |

## Verification
A wrong stored key shows up at the next write. Either a correct inverse key is refused, which leaves nmi_o and cnt_o unchanged, or a stale key is taken, which reloads cnt_o one cycle later. A wrong count or stage shows up as nmi_o or rst_req_o firing on the wrong tick, or as a reset request with no warning before it. The status outputs show either fault one cycle after the faulty edge. The bench runs full 256-tick countdowns so that off-by-one expiry and priority faults show up.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    STG_WATCH = 1'b0,
    STG_GRACE = 1'b1
  } stage_e;
endpackage

// File: rtl/wdt_key_guard.sv
module wdt_key_guard #(
  parameter int KEY_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             en_i,
  output logic             accept_o
);
  logic [KEY_W-1:0] key_q;
  logic             en_q;

  // unlocked while disabled; otherwise key must be inverse of last accepted
  assign accept_o = wr_i && (!en_q || (key_i == ~key_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      en_q  <= 1'b0;
    end else if (accept_o) begin
      key_q <= key_i;
      en_q  <= en_i;
    end
  end

  a_r3_reject_keeps_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !accept_o) |=> ($stable(key_q) && $stable(en_q)));
  a_r3_unlocked_takes_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !en_q) |-> accept_o);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int GRACE = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             nmi_o,
  output logic             stage_o,
  output logic             rst_req_o
);
  localparam logic [CNT_W-1:0] GRACE_CNT = CNT_W'(GRACE);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q, nmi_q, rst_q;
  stage_e           stage_q;
  logic             expire;

  assign expire = run_q && tick_i && (cnt_q <= CNT_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      nmi_q   <= 1'b0;
      rst_q   <= 1'b0;
      stage_q <= STG_WATCH;
    end else begin
      rst_q <= 1'b0;
      if (load_i) begin
        nmi_q   <= 1'b0;
        stage_q <= STG_WATCH;
        run_q   <= en_i;
        if (en_i) cnt_q <= cnt_i;
      end else if (expire) begin
        if (stage_q == STG_WATCH) begin
          nmi_q   <= 1'b1;
          stage_q <= STG_GRACE;
          cnt_q   <= GRACE_CNT;
        end else begin
          rst_q <= 1'b1;
          run_q <= 1'b0;
          cnt_q <= '0;
        end
      end else if (run_q && tick_i) begin
        cnt_q <= cnt_q - CNT_ONE;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign nmi_o     = nmi_q;
  assign stage_o   = (stage_q == STG_GRACE);
  assign rst_req_o = rst_q;

  a_r4_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!nmi_o && !stage_o));
  a_r6_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q));
  a_r7_nmi_enters_grace: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_o) |-> (stage_o && cnt_q == GRACE_CNT));
  a_r8_rst_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  a_r8_rst_after_warning: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (nmi_o && stage_o && $past(tick_i)));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int KEY_W = 7,
  parameter int CNT_W = 9,
  parameter int GRACE = 1,
  localparam int DATA_W = KEY_W + CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              nmi_o,
  output logic              rst_req_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              stage_o
);
  // enable sits in the count field's top bit; the count keeps it (behavioural overlap)
  localparam int EN_BIT  = CNT_W - 1;
  localparam int KEY_LSB = CNT_W;

  logic [KEY_W-1:0] wr_key;
  logic             wr_en;
  logic [CNT_W-1:0] wr_cnt;
  logic             accept;

  assign wr_key = wr_data_i[KEY_LSB +: KEY_W];
  assign wr_en  = wr_data_i[EN_BIT];
  assign wr_cnt = wr_data_i[CNT_W-1:0];

  wdt_key_guard #(.KEY_W(KEY_W)) u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .key_i    (wr_key),
    .en_i     (wr_en),
    .accept_o (accept)
  );

  wdt_counter #(.CNT_W(CNT_W), .GRACE(GRACE)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .load_i    (accept),
    .en_i      (wr_en),
    .cnt_i     (wr_cnt),
    .cnt_o     (cnt_o),
    .nmi_o     (nmi_o),
    .stage_o   (stage_o),
    .rst_req_o (rst_req_o)
  );

  a_r3_reject_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !accept && !tick_i) |=> ($stable(cnt_o) && $stable(nmi_o) && $stable(stage_o)));
  a_r5_enable_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && wr_en) |=> (cnt_o == $past(wr_cnt)));
endmodule

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  typedef struct packed {
    logic        wr;
    logic [15:0] data;
    logic [9:0]  ticks;
    logic [8:0]  cnt;
    logic        nmi;
    logic        stage;
    logic        rst;
  } vec_t;

  // data = {key[6:0], en, low8}; count = data[8:0]
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h2B04, 10'd0,   9'd260, 1'b0, 1'b0, 1'b0}, // key 15 load 260
    '{1'b0, 16'h0000, 10'd10,  9'd250, 1'b0, 1'b0, 1'b0}, // R6 count down
    '{1'b1, 16'h2B10, 10'd0,   9'd250, 1'b0, 1'b0, 1'b0}, // R3 stale key
    '{1'b1, 16'hD502, 10'd0,   9'd258, 1'b0, 1'b0, 1'b0}, // R5 key 6A
    '{1'b0, 16'h0000, 10'd257, 9'd1,   1'b0, 1'b0, 1'b0},
    '{1'b0, 16'h0000, 10'd1,   9'd1,   1'b1, 1'b1, 1'b0}, // R7 first expiry
    '{1'b1, 16'h2B00, 10'd0,   9'd256, 1'b0, 1'b0, 1'b0}, // R4 clears nmi
    '{1'b1, 16'hD405, 10'd0,   9'd256, 1'b0, 1'b0, 1'b0}, // R5 disable holds
    '{1'b0, 16'h0000, 10'd20,  9'd256, 1'b0, 1'b0, 1'b0}, // R5 stopped
    '{1'b1, 16'h6700, 10'd256, 9'd1,   1'b1, 1'b1, 1'b0}, // R3 unlocked key 33
    '{1'b0, 16'h0000, 10'd1,   9'd0,   1'b1, 1'b1, 1'b1}  // R8 reset request
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic       nmi_o, rst_req_o, stage_o;
  logic [8:0] cnt_o;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_keyed u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i),
    .wr_data_i(wr_data_i), .nmi_o(nmi_o), .rst_req_o(rst_req_o),
    .cnt_o(cnt_o), .stage_o(stage_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [8:0] c, input logic n,
                         input logic s, input logic r);
    chk({tag, " cnt"}, 32'(cnt_o), 32'(c));
    chk({tag, " nmi"}, 32'(nmi_o), 32'(n));
    chk({tag, " stage"}, 32'(stage_o), 32'(s));
    chk({tag, " rst_req"}, 32'(rst_req_o), 32'(r));
  endtask

  // drive at negedge, one edge, return at next negedge
  task automatic cyc(input logic w, input logic [15:0] d, input logic t);
    wr_i = w; wr_data_i = d; tick_i = t;
    @(posedge clk);
    @(negedge clk);
    wr_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0, 1'b1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 in reset", 9'd0, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_all("R1 after reset", 9'd0, 1'b0, 1'b0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr) cyc(1'b1, VECS[v].data, 1'b0);
      ticks(int'(VECS[v].ticks));
      chk_all($sformatf("R2 R9 vec%0d", v), VECS[v].cnt, VECS[v].nmi,
              VECS[v].stage, VECS[v].rst);
    end

    // R8 pulse is single, counter stopped afterwards
    cyc(1'b0, 16'h0, 1'b0);
    chk("R8 pulse width", 32'(rst_req_o), 32'd0);
    ticks(5);
    chk_all("R8 stopped", 9'd0, 1'b1, 1'b1, 1'b0);

    // R3 stored key 33 enabled: repeat of same key refused
    cyc(1'b1, 16'h6710, 1'b0);
    chk_all("R3 reject in grace", 9'd0, 1'b1, 1'b1, 1'b0);
    // R4 inverse key 4C with enable clear: clears nmi, stage; count held
    cyc(1'b1, 16'h9805, 1'b0);
    chk_all("R4 clear via disable", 9'd0, 1'b0, 1'b0, 1'b0);

    // R6 write beats tick: unlocked, key 11 load 0x1FF with tick same cycle
    cyc(1'b1, 16'h23FF, 1'b1);
    chk("R6 write priority", 32'(cnt_o), 32'h1FF);
    cyc(1'b0, 16'h0, 1'b0);
    chk("R6 no tick hold", 32'(cnt_o), 32'h1FF);
    // R3 wrong non-inverse key while a tick runs: only the tick acts
    cyc(1'b1, 16'h5510, 1'b1);
    chk("R3 reject with tick", 32'(cnt_o), 32'h1FE);

    // R1 async reset mid-run
    ticks(3);
    rst_ni = 1'b0;
    #1;
    chk_all("R1 async reset", 9'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    // R1 disabled after reset: any key accepted
    cyc(1'b1, 16'h0103, 1'b0);
    chk("R1 unlocked after reset", 32'(cnt_o), 32'h103);

    summary();
  end
endmodule